// File: doc/BRIEF.md
# M/N Fractional Rate Generator

This block turns a stream of source ticks into a thinner stream of single-cycle enable pulses whose average rate is the source rate divided by an integer, then scaled by a fraction M/N. Everything runs in one system clock domain. The output is a clock-enable strobe and not a clock.

Software programs three registers through a small write port. The first register holds the divisor field, which is the ratio minus one, and the bitwise inverse of (N − M). The second holds M at a configurable bit offset. The third holds the fractional-stage enable, a two-bit mode and a counter-reset bit. N is never stored as a plain value. It is rebuilt as the inverted field plus M, modulo the counter width.

The intended update order is: raise counter reset, rewrite the fractional values, then drop counter reset. When the fractional stage is not both enabled and in dual-edge mode, only the integer divisor acts.

Top module: `mn_rate_gen`

## Requirements
- R1: After reset `pulse_out` is 0, and the reset configuration (divisor field 0, fractional stage off) produces one output pulse per input tick.
- R2: With divisor field P (register 0, bits [W+PW-1:W]), an output pulse occurs on every (P+1)th accepted tick, and the first pulse comes on tick P+1.
- R3: The effective N equals the bitwise inverse of register 0 bits [W-1:0], plus M (register 1 bits [MS+W-1:MS]), taken modulo 2^W.
- R4: The fractional stage is active only when control bit 0 is 1 and control bits [2:1] equal 2'b10. In every other combination, each divided tick gives a pulse.
- R5: In fractional mode, starting from a cleared counter, the number of pulses after j divided ticks is floor(j·M/N).
- R6: While control bit 3 (counter reset) is 1, no pulse is produced and both the divider count and the accumulator are held at zero. After the bit is released, counting restarts from zero.
- R7: In fractional mode, if M > N or N = 0, no pulses are produced.
- R8: A pulse is high for exactly the cycle after the clock edge that accepted the tick which produced it.
- R9: A write to register address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor/N, 1 M, 2 control |
| wr_data | input | DW | Write data |
| tick_in | input | 1 | Source tick, one cycle per event |
| pulse_out | output | 1 | Output enable pulse |

## Verification
The assertions assume that `tick_in` is the only thing that can produce a pulse. They also assume that a configuration in which M exceeds N or N is zero is a legal input state, which must stay silent rather than being avoided. The stimulus changes the fractional values only while counter reset is held. Each scenario starts from cleared counters, so the floor(j·M/N) pulse counts hold exactly. Ticks are separated by idle cycles, so every pulse can be attributed to one tick.

// File: rtl/mn_rate_gen.sv
module mn_rate_gen #(
  parameter int W  = 8,
  parameter int PW = 4,
  parameter int MS = W + PW,
  parameter int DW = MS + W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick_in,
  output logic          pulse_out
);
  localparam logic [1:0] MODE_DUAL = 2'b10;

  logic [W-1:0]  nfld, m_val, acc, n_eff, diff;
  logic [PW-1:0] pdiv, pcnt;
  logic [1:0]    mode;
  logic          mn_en, cnt_rst;
  logic [W:0]    sum;
  logic          ptick, mn_on, bad, fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nfld <= '0; pdiv <= '0; m_val <= '0;
      mn_en <= 1'b0; mode <= 2'b00; cnt_rst <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin nfld <= wr_data[W-1:0]; pdiv <= wr_data[W+PW-1:W]; end
        2'd1: m_val <= wr_data[MS+W-1:MS];
        2'd2: {cnt_rst, mode, mn_en} <= wr_data[3:0];
        default: ;
      endcase
    end

  assign n_eff = ~nfld + m_val;
  assign mn_on = mn_en && (mode == MODE_DUAL);
  assign bad   = (m_val > n_eff) || (n_eff == '0);
  assign ptick = tick_in && (pcnt >= pdiv);
  assign sum   = {1'b0, acc} + {1'b0, m_val};
  assign fire  = sum >= {1'b0, n_eff};
  assign diff  = W'(sum - {1'b0, n_eff});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0; acc <= '0; pulse_out <= 1'b0;
    end else if (cnt_rst) begin
      pcnt <= '0; acc <= '0; pulse_out <= 1'b0;
    end else begin
      if (tick_in) pcnt <= ptick ? '0 : pcnt + 1'b1;
      if (ptick && mn_on && !bad) acc <= fire ? diff : sum[W-1:0];
      pulse_out <= ptick && (mn_on ? (!bad && fire) : 1'b1);
    end
endmodule

// File: rtl/mn_rate_gen_chk.sv
module mn_rate_gen_chk #(
  parameter int W  = 8,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_in,
  input logic          pulse_out,
  input logic          cnt_rst,
  input logic          mn_on,
  input logic          bad,
  input logic [W-1:0]  acc,
  input logic [PW-1:0] pcnt
);
  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> $past(tick_in));
  // R6
  reset_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_rst) |-> !pulse_out);
  // R6
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_rst) |-> (acc == '0 && pcnt == '0));
  // R7
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mn_on && bad) |-> !pulse_out);
endmodule

bind mn_rate_gen mn_rate_gen_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .pulse_out(pulse_out),
  .cnt_rst(cnt_rst), .mn_on(mn_on), .bad(bad), .acc(acc), .pcnt(pcnt)
);

// File: tb/tb_mn_rate_gen.sv
`timescale 1ns/1ps
module tb_mn_rate_gen;
  localparam int W = 8, PW = 4, MS = W + PW, DW = MS + W;

  logic clk = 0, rst_n = 0, wr_en = 0, tick_in = 0;
  logic [1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic pulse_out;
  int checks = 0, errors = 0, pcount = 0;
  bit done = 0;

  mn_rate_gen #(.W(W), .PW(PW)) dut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (pulse_out) pcount++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // ctl: bit0 enable, [2:1] mode, bit3 counter reset
  task automatic cfg(input int n, input int m, input int p, input logic [3:0] ctl);
    logic [W-1:0] inv;
    inv = ~W'(n - m);
    wr(2'd2, DW'({1'b1, ctl[2:0]}));
    wr(2'd0, DW'({PW'(p), inv}));
    wr(2'd1, DW'(W'(m)) << MS);
    wr(2'd2, DW'({1'b0, ctl[2:0]}));
  endtask

  task automatic ticks(input int n, input int exp, input string req);
    pcount = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1;
      @(negedge clk); tick_in = 0;
    end
    repeat (2) @(negedge clk);
    check(req, pcount, exp);
  endtask

  task automatic t_reset;
    check("R1 reset", int'(pulse_out), 0);
    ticks(5, 5, "R1 default bypass");
  endtask

  task automatic t_prediv;
    cfg(1, 1, 2, 4'b0000);
    ticks(2, 0, "R2 before first");
    ticks(1, 1, "R2 first on third");
    ticks(9, 3, "R2 divide by 3");
  endtask

  task automatic t_timing;
    cfg(1, 1, 0, 4'b0000);
    @(negedge clk); tick_in = 1;
    @(negedge clk); tick_in = 0;
    check("R8 pulse next cycle", int'(pulse_out), 1);
    @(negedge clk);
    check("R8 single cycle", int'(pulse_out), 0);
  endtask

  task automatic t_frac;
    cfg(8, 3, 0, 4'b0101);
    ticks(16, 6, "R5 M3 N8");
    cfg(7, 5, 0, 4'b0101);
    ticks(14, 10, "R3 R5 M5 N7");
    cfg(3, 1, 1, 4'b0101);
    ticks(12, 2, "R5 M1 N3 div2");
  endtask

  task automatic t_mode;
    cfg(8, 3, 0, 4'b0011);
    ticks(6, 6, "R4 mode 01 bypass");
    cfg(8, 3, 0, 4'b0100);
    ticks(6, 6, "R4 enable off bypass");
  endtask

  task automatic t_invalid;
    cfg(5, 9, 0, 4'b0101);
    ticks(8, 0, "R7 M above N");
    cfg(0, 4, 0, 4'b0101);
    ticks(8, 0, "R7 N zero");
  endtask

  task automatic t_cntrst;
    cfg(8, 3, 0, 4'b0101);
    wr(2'd2, DW'(4'b1101));
    ticks(8, 0, "R6 held silent");
    wr(2'd2, DW'(4'b0101));
    ticks(2, 0, "R6 partial");
    wr(2'd2, DW'(4'b1101));
    wr(2'd2, DW'(4'b0101));
    ticks(2, 0, "R6 accumulator cleared");
    ticks(1, 1, "R6 restart");
  endtask

  task automatic t_addr3;
    cfg(1, 1, 1, 4'b0000);
    wr(2'd3, '1);
    ticks(6, 3, "R9 addr3 ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_prediv;
    t_timing;
    t_frac;
    t_mode;
    t_invalid;
    t_cntrst;
    t_addr3;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule